// File: doc/BRIEF.md
# Programmable Nested-Loop Address Generator

This block sequences the address port of a 16-bit-wide embedded memory of 512 or 1024 words. Over a configuration write port, a short program is loaded into a small local store. Each program word describes up to three nested loops. A word holds a base address, an iteration count for each level and a signed stride for each level. The block can also run a triangular mode. In that mode the inner loop length grows with the middle index, which suits the index patterns of covariance-matrix kernels.

A start command from the host opens a data-flow thread. The block then offers one address per clock while the downstream ready signal is high, and holds the current address while ready is low. Each address carries a two-bit token. The token marks the end of every innermost vector, and it marks the final address of the whole program as the end of the matrix. Once that final address is taken, the block pulses done back to the host and becomes idle.

Top module: `loop_addr_gen`

## Requirements
- R1: After reset, `valid` and `done` are 0 until a start is accepted.
- R2: The address issued is (base + i0*s0 + i1*s1 + i2*s2) modulo 2^AW. Index i0 is the innermost and steps fastest, then i1, then i2. Each index runs from 0 to its count minus 1.
- R3: A count field of 0 is treated as one iteration.
- R4: Strides are two's-complement signed, so negative strides walk addresses downward.
- R5: In triangular mode (word bit 58 set), the innermost loop runs i1+1 iterations for each value of i1, and field c0 is ignored.
- R6: The token `tag` is 2'b01 on the last address of each innermost loop and 2'b10 on the final address of the program. The 2'b10 code takes precedence over 2'b01. Every other address carries 2'b00, and 2'b11 never appears.
- R7: While `rdy` is low, `addr` and `tag` hold steady. No address is skipped or issued twice.
- R8: The program words are laid out as {stop[59], tri[58], base[57:48], s2[47:40], s1[39:32], s0[31:24], c2[23:16], c1[15:8], c0[7:0]} and written with `cfg_we`/`cfg_slot`. Words run from slot 0 in order and end after a word whose stop bit is set, or after the last slot.
- R9: `done` is a one-cycle pulse in the cycle after the final address is accepted. `valid` falls in that same cycle.
- R10: A start while a thread is running is ignored. This includes a start in the very cycle the final address is accepted.
- R11: A start while idle is accepted. `valid` rises in the next cycle with the first address of slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Program word write strobe |
| cfg_slot | input | PW | Program slot written |
| cfg_word | input | WW | Program word data |
| start | input | 1 | Host start command |
| rdy | input | 1 | Downstream ready |
| valid | output | 1 | Address valid (thread running) |
| addr | output | AW | Memory address |
| tag | output | 2 | Token: 00 data, 01 end of vector, 10 end of matrix |
| done | output | 1 | Thread-complete pulse to host |

## Verification
The handshake that takes the final address and a fresh host start can land in the same cycle. This collision decides whether a new thread opens or the start is dropped. The bench provokes it by raising start exactly when its model holds one address in flight with ready high. It also issues starts on the done cycle and at random points mid-thread. A behavioural model checks that the colliding start is lost and that the start on the done cycle opens a new thread.

// File: rtl/loop_addr_gen.sv
module loop_addr_gen #(
  parameter int AW = 10,
  parameter int CW = 8,
  parameter int SW = 8,
  parameter int PDEPTH = 4,
  localparam int PW = (PDEPTH > 1) ? $clog2(PDEPTH) : 1,
  localparam int WW = 3*CW + 3*SW + AW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [PW-1:0] cfg_slot,
  input  logic [WW-1:0] cfg_word,
  input  logic          start,
  input  logic          rdy,
  output logic          valid,
  output logic [AW-1:0] addr,
  output logic [1:0]    tag,
  output logic          done
);
  localparam int XW = AW + CW + SW + 4;

  logic [WW-1:0] prog [PDEPTH];
  logic [PW-1:0] pc;
  logic [CW-1:0] i0, i1, i2;
  logic          busy;

  always_ff @(posedge clk)
    if (cfg_we) prog[cfg_slot] <= cfg_word;

  logic [WW-1:0] cur;
  assign cur = prog[pc];

  logic [CW-1:0] c0, c1, c2;
  logic signed [SW-1:0] s0, s1, s2;
  logic [AW-1:0] base;
  logic tri_m, stop;
  assign c0    = cur[CW-1:0];
  assign c1    = cur[2*CW-1:CW];
  assign c2    = cur[3*CW-1:2*CW];
  assign s0    = cur[3*CW+SW-1:3*CW];
  assign s1    = cur[3*CW+2*SW-1:3*CW+SW];
  assign s2    = cur[3*CW+3*SW-1:3*CW+2*SW];
  assign base  = cur[3*CW+3*SW+AW-1:3*CW+3*SW];
  assign tri_m = cur[WW-2];
  assign stop  = cur[WW-1];

  logic [CW:0]   n0;
  logic [CW-1:0] n1, n2;
  assign n0 = tri_m ? ({1'b0, i1} + 1'b1) : ((c0 == '0) ? (CW+1)'(1) : {1'b0, c0});
  assign n1 = (c1 == '0) ? CW'(1) : c1;
  assign n2 = (c2 == '0) ? CW'(1) : c2;

  logic last0, last1, last2, last_word, final_a, fire;
  assign last0     = ({1'b0, i0} == n0 - 1'b1);
  assign last1     = (i1 == n1 - 1'b1);
  assign last2     = (i2 == n2 - 1'b1);
  assign last_word = stop || (pc == PW'(PDEPTH-1));
  assign final_a   = last0 && last1 && last2 && last_word;
  assign fire      = busy && rdy;

  logic signed [XW-1:0] sum;
  always_comb begin
    sum = XW'($signed({1'b0, base}))
        + XW'($signed({1'b0, i0})) * XW'(s0)
        + XW'($signed({1'b0, i1})) * XW'(s1)
        + XW'($signed({1'b0, i2})) * XW'(s2);
  end

  assign valid = busy;
  assign addr  = sum[AW-1:0];
  assign tag   = !busy ? 2'b00 : final_a ? 2'b10 : last0 ? 2'b01 : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      pc   <= '0;
      i0   <= '0;
      i1   <= '0;
      i2   <= '0;
    end else begin
      done <= fire && final_a;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          pc   <= '0;
          i0   <= '0;
          i1   <= '0;
          i2   <= '0;
        end
      end else if (fire) begin
        if (final_a) begin
          busy <= 1'b0;
        end else if (!last0) begin
          i0 <= i0 + 1'b1;
        end else begin
          i0 <= '0;
          if (!last1) begin
            i1 <= i1 + 1'b1;
          end else begin
            i1 <= '0;
            if (!last2) begin
              i2 <= i2 + 1'b1;
            end else begin
              i2 <= '0;
              pc <= pc + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/loop_addr_gen_chk.sv
module loop_addr_gen_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          rdy,
  input logic          valid,
  input logic [AW-1:0] addr,
  input logic [1:0]    tag,
  input logic          done
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> tag == 2'b00);

  p_tag_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> tag != 2'b11);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !rdy |=> valid && $stable(addr) && $stable(tag));

  p_done_after_final_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid && rdy && tag == 2'b10 |=> done && !valid);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid && start && !(rdy && tag == 2'b10) |=> valid);

  p_idle_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !valid && start |=> valid);
endmodule

bind loop_addr_gen loop_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rdy(rdy), .valid(valid),
  .addr(addr), .tag(tag), .done(done)
);

// File: tb/sim_loop_addr_gen.sv
`timescale 1ns/1ps
module sim_loop_addr_gen;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_slot = 0;
  logic [59:0] cfg_word = 0;
  logic        start = 0;
  logic        rdy = 0;
  logic        valid;
  logic [9:0]  addr;
  logic [1:0]  tag;
  logic        done;

  always #4 clk = ~clk;

  loop_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_word(cfg_word), .start(start), .rdy(rdy), .valid(valid),
    .addr(addr), .tag(tag), .done(done)
  );

  int tests = 0, fails = 0;
  logic [59:0] bp [4];
  int qa[$], qt[$];
  bit m_busy = 0, m_done = 0;
  string cur_req = "R2";

  function automatic logic [59:0] mk(bit stop, bit tr, int base, int s2, int s1, int s0,
                                     int c2, int c1, int c0);
    logic [9:0] b = base[9:0];
    logic [7:0] x2 = s2[7:0], x1 = s1[7:0], x0 = s0[7:0];
    logic [7:0] k2 = c2[7:0], k1 = c1[7:0], k0 = c0[7:0];
    return {stop, tr, b, x2, x1, x0, k2, k1, k0};
  endfunction

  task automatic gen();
    qa.delete(); qt.delete();
    for (int p = 0; p < 4; p++) begin
      logic [59:0] w = bp[p];
      int c0 = w[7:0], c1 = w[15:8], c2 = w[23:16];
      int s0 = $signed(w[31:24]), s1 = $signed(w[39:32]), s2 = $signed(w[47:40]);
      int base = w[57:48];
      int n1 = (c1 == 0) ? 1 : c1;
      int n2 = (c2 == 0) ? 1 : c2;
      for (int j2 = 0; j2 < n2; j2++)
        for (int j1 = 0; j1 < n1; j1++) begin
          int n0 = w[58] ? j1 + 1 : ((c0 == 0) ? 1 : c0);
          for (int j0 = 0; j0 < n0; j0++) begin
            qa.push_back((base + j0*s0 + j1*s1 + j2*s2) & 1023);
            qt.push_back((j0 == n0 - 1) ? 1 : 0);
          end
        end
      if (w[59]) break;
    end
    qt[qt.size()-1] = 2;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(bit st, bit rd);
    bit was_busy, fire, fin;
    @(negedge clk);
    chk("R9", "valid", valid, m_busy);
    chk("R9", "done", done, m_done);
    if (m_busy && valid) begin
      chk(cur_req, "addr", addr, qa[0]);
      chk("R6", "tag", tag, qt[0]);
    end
    was_busy = m_busy;
    fire = m_busy && rd;
    fin = fire && (qa.size() == 1);
    m_done = fin;
    if (fire) begin
      void'(qa.pop_front()); void'(qt.pop_front());
      if (fin) m_busy = 0;
    end
    if (st && !was_busy) begin
      gen();
      m_busy = 1;
    end
    start = st;
    rdy = rd;
  endtask

  task automatic wr(int slot, logic [59:0] w);
    @(negedge clk);
    cfg_we = 1; cfg_slot = slot[1:0]; cfg_word = w;
    bp[slot] = w;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run(string req, int rdy_pct);
    cur_req = req;
    tick(1, ($urandom_range(99) < rdy_pct));
    for (int k = 0; k < 2000 && (m_busy || m_done); k++)
      tick(0, ($urandom_range(99) < rdy_pct));
    tick(0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", "valid in reset", valid, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1", "valid after reset", valid, 0);
    chk("R1", "done after reset", done, 0);

    // R2, R3: plain 2-level walk, c2 = 0 means one pass
    wr(0, mk(1, 0, 100, 0, 16, 1, 0, 3, 4));
    run("R2", 100);
    run("R3", 60);

    // R4: negative strides, R7 heavy stalls
    wr(0, mk(1, 0, 500, 100, -50, -2, 2, 2, 3));
    run("R4", 100);
    run("R7", 25);

    // R5 triangular then R8 all four slots, wraps modulo 1024
    wr(0, mk(0, 1, 0, 0, 32, 1, 1, 4, 9));
    wr(1, mk(0, 0, 1000, 0, 0, 10, 1, 1, 5));
    wr(2, mk(0, 0, 7, 3, 0, 1, 2, 0, 2));
    wr(3, mk(0, 0, 900, 0, 0, -7, 0, 0, 3));
    run("R5", 100);
    run("R8", 50);

    // R10 / R11: starts everywhere, including at final acceptance
    wr(0, mk(1, 0, 20, 0, 8, 1, 1, 2, 3));
    cur_req = "R10";
    for (int k = 0; k < 400; k++) begin
      bit rd = ($urandom_range(99) < 70);
      bit st = (m_busy && qa.size() == 1 && rd) ? 1'b1 : ($urandom_range(99) < 30);
      tick(st, rd);
    end
    cur_req = "R11";
    for (int k = 0; k < 200; k++) tick(!m_busy, 1);
    for (int k = 0; k < 20; k++) tick(0, 1);
    chk("R11", "idle at end", valid, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule